// File: doc/BRIEF.md
# Registered Bit Counting Unit

This block evaluates one of three counts on a general-purpose operand: the number of set bits, the run of zeros measured down from the top bit, and the run of zeros measured up from the bottom bit. A two-bit opcode selects which count is wanted. The operand and opcode are qualified by a valid strobe. One clock later the selected count appears on a registered result bus with a registered valid and two status flags, zero and carry.

The zero-run counts are defined for every input. An all-zero operand gives a count equal to the operand width and raises carry, so software never has to test for an empty operand on its own. The operand width is a parameter that takes the values 16, 32 or 64, and the result bus is wide enough to hold the width itself.

Top module: `bitcount_unit`

## Requirements
- R1: With opcode 2'b00, the result is the number of 1 bits in the operand.
- R2: With opcode 2'b01, the result is the number of consecutive zero bits counted from the most significant bit down to the first 1.
- R3: With opcode 2'b01 and an all-zero operand, the result equals WIDTH and carry is set. For any nonzero operand, carry is clear.
- R4: With opcode 2'b10, the result is the number of consecutive zero bits counted from the least significant bit up to the first 1. An all-zero operand gives WIDTH with carry set, and a nonzero operand clears carry.
- R5: For opcodes 2'b01 and 2'b10, the zero flag is set exactly when the result is 0. That is the case when the most significant bit (2'b01) or the least significant bit (2'b10) is 1.
- R6: With opcode 2'b00, the zero flag is set exactly when the operand is all zero, and carry is always clear.
- R7: Opcode 2'b11 gives a result of 0 with both flags clear.
- R8: `out_valid` is high in the cycle after each clock edge that samples `in_valid` high, and low after an edge that samples it low. Result and flags belong to the operand sampled at that edge.
- R9: While reset is asserted, `out_valid`, the result and both flags are 0.
- R10: An edge with `in_valid` low leaves the result and flags unchanged, whatever the operand and opcode are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and opcode are valid this cycle |
| in_op | input | 2 | Count select: 00 set bits, 01 leading zeros, 10 trailing zeros, 11 reserved |
| in_operand | input | WIDTH | Operand to be counted |
| out_valid | output | 1 | Registered result is fresh |
| out_result | output | $clog2(WIDTH)+1 | Registered count |
| out_zf | output | 1 | Zero flag |
| out_cf | output | 1 | Carry flag (zero-run count on an all-zero operand) |

## Verification
Each result, flag and valid is due exactly one rising edge after the operand is sampled, because the counts reach the output register with no further pipeline stage. The bench drives each input on a falling edge and samples the outputs on the next falling edge. That point is half a period after the capturing edge and comes before the following one. For the hold rule, the bench lowers the strobe, changes the operand and opcode, and samples again one falling edge later. The result must then show the previous values and a low valid.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

   typedef enum logic [1:0] {
      BCU_OP_POP = 2'b00,
      BCU_OP_LZC = 2'b01,
      BCU_OP_TZC = 2'b10,
      BCU_OP_RSV = 2'b11
   } bcu_op_e;

   function automatic bit bcu_width_ok(input int w);
      return (w == 16) || (w == 32) || (w == 64);
   endfunction

   function automatic int bcu_count_bits(input int w);
      return $clog2(w) + 1;
   endfunction

endpackage

// File: rtl/bcu_popcount.sv
module bcu_popcount #(
   parameter int WIDTH = 32,
   parameter int CW    = $clog2(WIDTH) + 1
) (
   input  logic [WIDTH-1:0] vec,
   output logic [CW-1:0]    count
);
   localparam int NODES = 2 * WIDTH;

   // heap-ordered adder tree: node k sums nodes 2k and 2k+1, leaves at WIDTH+i
   logic [CW-1:0] node_sum [1:NODES-1];

   for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
      assign node_sum[WIDTH+i] = {{(CW-1){1'b0}}, vec[i]};
   end

   for (genvar k = 1; k < WIDTH; k++) begin : g_node
      assign node_sum[k] = node_sum[2*k] + node_sum[2*k+1];
   end

   assign count = node_sum[1];
endmodule

// File: rtl/bcu_zero_run.sv
module bcu_zero_run #(
   parameter int WIDTH    = 32,
   parameter bit FROM_MSB = 1'b0,
   parameter int CW       = $clog2(WIDTH) + 1
) (
   input  logic [WIDTH-1:0] vec,
   output logic [CW-1:0]    count,
   output logic             all_zero
);
   localparam int NODES = 2 * WIDTH;

   logic [WIDTH-1:0] scan;

   // orient so that the run always starts at scan[0]
   if (FROM_MSB) begin : g_rev
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign scan[i] = vec[WIDTH-1-i];
      end
   end else begin : g_fwd
      assign scan = vec;
   end

   // node k covers a contiguous span; child 2k holds the lower-index half
   logic [CW-1:0] run_len [1:NODES-1];
   logic          span_z  [1:NODES-1];

   for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
      assign span_z[WIDTH+i]  = ~scan[i];
      assign run_len[WIDTH+i] = {{(CW-1){1'b0}}, ~scan[i]};
   end

   for (genvar k = 1; k < WIDTH; k++) begin : g_node
      assign span_z[k]  = span_z[2*k] & span_z[2*k+1];
      assign run_len[k] = span_z[2*k] ? (run_len[2*k] + run_len[2*k+1])
                                      : run_len[2*k];
   end

   assign count    = run_len[1];
   assign all_zero = span_z[1];
endmodule

// File: rtl/bcu_result_stage.sv
module bcu_result_stage
   import bcu_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int CW    = $clog2(WIDTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  bcu_op_e       op,
   input  logic [CW-1:0] pop_cnt,
   input  logic [CW-1:0] lead_cnt,
   input  logic          lead_empty,
   input  logic [CW-1:0] trail_cnt,
   input  logic          trail_empty,
   output logic          out_valid,
   output logic [CW-1:0] out_result,
   output logic          out_zf,
   output logic          out_cf
);
   logic [CW-1:0] sel_cnt;
   logic          sel_cf;
   logic          sel_zf;

   always_comb begin
      sel_cnt = '0;
      sel_cf  = 1'b0;
      unique case (op)
         BCU_OP_POP: sel_cnt = pop_cnt;
         BCU_OP_LZC: begin
            sel_cnt = lead_cnt;
            sel_cf  = lead_empty;
         end
         BCU_OP_TZC: begin
            sel_cnt = trail_cnt;
            sel_cf  = trail_empty;
         end
         default: begin
            sel_cnt = '0;
            sel_cf  = 1'b0;
         end
      endcase
      sel_zf = (op != BCU_OP_RSV) && (sel_cnt == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_zf     <= 1'b0;
         out_cf     <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result <= sel_cnt;
            out_zf     <= sel_zf;
            out_cf     <= sel_cf;
         end
      end
   end
endmodule

// File: rtl/bitcount_unit.sv
module bitcount_unit
   import bcu_pkg::*;
#(
   parameter int   WIDTH = 32,
   localparam int  CW    = $clog2(WIDTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_op,
   input  logic [WIDTH-1:0] in_operand,
   output logic             out_valid,
   output logic [CW-1:0]    out_result,
   output logic             out_zf,
   output logic             out_cf
);
   if (!bcu_width_ok(WIDTH)) begin : g_bad_width
      $error("bitcount_unit: WIDTH must be 16, 32 or 64");
   end
   if (CW != bcu_count_bits(WIDTH)) begin : g_bad_cw
      $error("bitcount_unit: result width mismatch");
   end

   logic [CW-1:0] pop_cnt;
   logic [CW-1:0] lead_cnt;
   logic [CW-1:0] trail_cnt;
   logic          lead_empty;
   logic          trail_empty;

   bcu_popcount #(.WIDTH(WIDTH), .CW(CW)) i_pop (
      .vec   (in_operand),
      .count (pop_cnt)
   );

   bcu_zero_run #(.WIDTH(WIDTH), .FROM_MSB(1'b1), .CW(CW)) i_lead (
      .vec      (in_operand),
      .count    (lead_cnt),
      .all_zero (lead_empty)
   );

   bcu_zero_run #(.WIDTH(WIDTH), .FROM_MSB(1'b0), .CW(CW)) i_trail (
      .vec      (in_operand),
      .count    (trail_cnt),
      .all_zero (trail_empty)
   );

   bcu_result_stage #(.WIDTH(WIDTH), .CW(CW)) i_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .op          (bcu_op_e'(in_op)),
      .pop_cnt     (pop_cnt),
      .lead_cnt    (lead_cnt),
      .lead_empty  (lead_empty),
      .trail_cnt   (trail_cnt),
      .trail_empty (trail_empty),
      .out_valid   (out_valid),
      .out_result  (out_result),
      .out_zf      (out_zf),
      .out_cf      (out_cf)
   );
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
   parameter int  WIDTH = 32,
   localparam int CW    = $clog2(WIDTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       in_op,
   input logic [WIDTH-1:0] in_operand,
   input logic             out_valid,
   input logic [CW-1:0]    out_result,
   input logic             out_zf,
   input logic             out_cf
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8
   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R8
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_result) && $stable(out_zf) && $stable(out_cf))); // R10
   AST_POP_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b00) |=> (!out_cf && (out_zf == (out_result == '0)))); // R6
   AST_LEAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b01 && in_operand == '0) |=> (out_cf && out_result == CW'(WIDTH))); // R3
   AST_TRAIL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b10 && in_operand == '0) |=> (out_cf && out_result == CW'(WIDTH))); // R4
   AST_LEAD_TOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b01 && in_operand[WIDTH-1]) |=> (out_zf && !out_cf && out_result == '0)); // R5
   AST_RESERVED_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b11) |=> (out_result == '0 && !out_zf && !out_cf)); // R7
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !out_valid); // R9
endmodule

bind bitcount_unit bcu_checker #(.WIDTH(WIDTH)) i_bcu_checker (.*);

// File: tb/test_bitcount_unit.sv
module test_bitcount_unit;
   localparam int W  = 32;
   localparam int CW = $clog2(W) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    in_op = 2'b00;
   logic [W-1:0]  in_operand = '0;
   logic          out_valid;
   logic [CW-1:0] out_result;
   logic          out_zf;
   logic          out_cf;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   bitcount_unit #(.WIDTH(W)) i_bitcount_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_operand(in_operand), .out_valid(out_valid), .out_result(out_result),
      .out_zf(out_zf), .out_cf(out_cf)
   );

   function automatic int ref_pop(input logic [W-1:0] v);
      int n = 0;
      for (int i = 0; i < W; i++) if (v[i]) n++;
      return n;
   endfunction

   function automatic int ref_lead(input logic [W-1:0] v);
      for (int i = W - 1; i >= 0; i--) if (v[i]) return W - 1 - i;
      return W;
   endfunction

   function automatic int ref_trail(input logic [W-1:0] v);
      for (int i = 0; i < W; i++) if (v[i]) return i;
      return W;
   endfunction

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // drive one operation on a falling edge, sample at the next falling edge
   task automatic apply(input logic [1:0] op, input logic [W-1:0] v);
      int    e_res;
      bit    e_zf, e_cf;
      string rq;
      in_valid   = 1'b1;
      in_op      = op;
      in_operand = v;
      case (op)
         2'b00: begin e_res = ref_pop(v);   e_zf = (v == '0);   e_cf = 1'b0;        rq = "R1"; end
         2'b01: begin e_res = ref_lead(v);  e_zf = (e_res == 0); e_cf = (v == '0);   rq = "R2"; end
         2'b10: begin e_res = ref_trail(v); e_zf = (e_res == 0); e_cf = (v == '0);   rq = "R4"; end
         default: begin e_res = 0;          e_zf = 1'b0;        e_cf = 1'b0;        rq = "R7"; end
      endcase
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8", "valid", out_valid, 1);
      chk(rq, "result", out_result, e_res);
      chk(op == 2'b00 ? "R6" : (op == 2'b11 ? "R7" : "R5"), "zero flag", out_zf, e_zf);
      chk(op == 2'b00 ? "R6" : (op == 2'b01 ? "R3" : (op == 2'b10 ? "R4" : "R7")),
          "carry flag", out_cf, e_cf);
   endtask

   // idle cycle with changed inputs: outputs must not move
   task automatic idle_check(input logic [W-1:0] v);
      logic [CW-1:0] r0;
      logic          z0, c0;
      r0 = out_result; z0 = out_zf; c0 = out_cf;
      in_valid   = 1'b0;
      in_op      = 2'b10;
      in_operand = v;
      @(negedge clk);
      chk("R8", "valid idle", out_valid, 0);
      chk("R10", "result held", out_result, r0);
      chk("R10", "zf held", out_zf, z0);
      chk("R10", "cf held", out_cf, c0);
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      chk("R9", "valid in reset", out_valid, 0);
      chk("R9", "result in reset", out_result, 0);
      chk("R9", "flags in reset", {out_zf, out_cf}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "valid after reset", out_valid, 0);

      // directed corners
      for (int op = 0; op < 4; op++) begin
         apply(2'(op), '0);
         apply(2'(op), '1);
         apply(2'(op), {1'b1, {(W-1){1'b0}}});
         apply(2'(op), {{(W-1){1'b0}}, 1'b1});
      end
      for (int k = 0; k < W; k++) begin
         apply(2'b01, W'(1) << k);
         apply(2'b10, W'(1) << k);
         apply(2'b01, ~W'(0) >> k);
         apply(2'b10, ~W'(0) << k);
      end
      apply(2'b00, {(W/2){2'b10}});
      idle_check('0);
      apply(2'b01, '0);
      idle_check('1);
      apply(2'b11, '1);
      idle_check(W'(5));

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         logic [W-1:0] v;
         int           shape;
         v     = W'({$urandom, $urandom});
         shape = $urandom_range(0, 4);
         case (shape)
            1: v = v & W'($urandom) & W'($urandom);
            2: v = v | W'($urandom) | W'($urandom);
            3: v = v >> $urandom_range(0, W - 1);
            4: v = v << $urandom_range(0, W - 1);
            default: ;
         endcase
         apply(2'($urandom_range(0, 3)), v);
         if ($urandom_range(0, 9) == 0) idle_check(W'($urandom));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule